// File: doc/BRIEF.md
# Self-Reloading Periodic Tick Timer

This block is a register-mapped periodic timer built around a down counter that reloads itself. Software loads a reload value and turns the counter on. The counter then steps down to zero, reloads on the tick after that, and keeps going. Each pass from one to zero sets a sticky count flag, and can also raise a one-cycle interrupt pulse if the interrupt is enabled.

The counter steps on every core clock, or on rising edges of an external reference signal. When counting the reference, the block synchronises that signal with two flops on the core clock and detects its rising edges there. A read-only calibration register returns a value taken from tie-off inputs; by convention it is the reload value that gives a 10 ms interval. Software reaches the block through a simple single-cycle register bus. Writes take effect at the clock edge. Read data is registered and is valid in the cycle after the read is presented.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, the reload value and the current count all read 0 and `irq_o` is low. While the enable bit is 0, the current count does not change except through a write to the current-value register.
- R2: With enable (control bit 0) set and the source bit clear, the counter steps once per core clock. Each step loads the reload value when the count is 0 and decrements the count otherwise. For a reload value N, `irq_o` pulses for one cycle every N+1 clocks, in the cycle in which the count becomes 0.
- R3: With source (control bit 2) set, the counter steps once per rising edge of `ref_clk_i`. The timer synchronises that input through two flops on the core clock before detecting the edge. If each phase of the reference lasts K clocks, the interrupt period is (N+1)*2K clocks.
- R4: The count flag (control bit 16) sets when the counter steps from 1 to 0. A read of the control register at offset 0x0 returns the flag and then clears it. If a new set happens in the same cycle as the read, the flag stays set.
- R5: Any write to the current-value register (offset 0x8) sets the count and the flag to 0. The next step then loads the reload value, so the next interrupt comes N+1 steps after the write.
- R6: A read of the calibration register (offset 0xC) returns `calib_i`, zero-extended to 32 bits.
- R7: Bits 31:24 of the reload register (offset 0x4) and of the current-value register always read as 0.
- R8: With a reload value of 0, the counter stays at 0 once it reaches 0. Neither the flag nor the interrupt is raised.
- R9: `irq_o` pulses only while the interrupt-enable bit (control bit 1) is set. When that bit is clear, the flag still sets.
- R10: Control bits 0, 1 and 2 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset; bits 3:2 select the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after a read |
| ref_clk_i | input | 1 | External reference, asynchronous to `clk` |
| calib_i | input | CNT_W (24) | Tie-off calibration value |
| irq_o | output | 1 | One-cycle tick interrupt pulse |

## Verification
The checker tests several rules on every cycle. An interrupt pulse only appears with the count at zero and the interrupt enabled. A disabled counter holds its value. A current-value write always leaves count and flag at zero. A zero reload holds the counter at zero. Reads of the reload and current registers never show upper bits. Only the bench's scenarios can show the exact interrupt period for each reload value and reference phase length, the restart timing after a mid-count write, the clear-on-read of the flag, the calibration readback and the reset values.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Register select, decoded from address bits 3:2
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  localparam int BIT_EN    = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLAG  = 16;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter bit HAS_REF = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic rise_o
);
  generate
    if (HAS_REF) begin : g_sync
      logic [2:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], ref_i};
      end
      // sh[1] is the synchronised level, sh[2] its previous value
      assign rise_o = sh[1] & ~sh[2];
    end else begin : g_none
      assign rise_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr_i)          count_o <= '0;
    else if (step_i) begin
      if (count_o == '0)       count_o <= reload_i;
      else                     count_o <= count_o - ONE;
    end
  end

  // Step from one to zero in this cycle
  assign wrap_o = step_i & ~clr_i & (count_o == ONE);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 24,
  parameter bit HAS_REF = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_clk_i,
  input  logic [CNT_W-1:0]  calib_i,
  output logic              irq_o
);
  import tick_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e         rsel;
  logic             wr_ctrl, wr_reload, wr_count, rd_ctrl;
  logic             en_q, ie_q, src_q, flag_q;
  logic [CNT_W-1:0] reload_q, cnt_val;
  logic             ref_rise, step, wrap;

  assign rsel      = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl   = bus_sel &  bus_wr & (rsel == SEL_CTRL);
  assign wr_reload = bus_sel &  bus_wr & (rsel == SEL_RELOAD);
  assign wr_count  = bus_sel &  bus_wr & (rsel == SEL_COUNT);
  assign rd_ctrl   = bus_sel & ~bus_wr & (rsel == SEL_CTRL);

  tick_ref_sync #(.HAS_REF(HAS_REF)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .ref_i  (ref_clk_i),
    .rise_o (ref_rise)
  );

  assign step = en_q & (src_q ? ref_rise : 1'b1);

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step),
    .clr_i    (wr_count),
    .reload_i (reload_q),
    .count_o  (cnt_val),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      src_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[BIT_EN];
        ie_q  <= bus_wdata[BIT_IE];
        src_q <= HAS_REF ? bus_wdata[BIT_SRC] : 1'b0;
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // Count flag: clear by current-value write, set on wrap, clear on read
  always_ff @(posedge clk) begin
    if (rst || wr_count) flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (rd_ctrl)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= wrap & ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) begin
      bus_rdata <= '0;
      unique case (rsel)
        SEL_CTRL: begin
          bus_rdata[BIT_EN]   <= en_q;
          bus_rdata[BIT_IE]   <= ie_q;
          bus_rdata[BIT_SRC]  <= src_q;
          bus_rdata[BIT_FLAG] <= flag_q;
        end
        SEL_RELOAD: bus_rdata <= {{PAD_W{1'b0}}, reload_q};
        SEL_COUNT:  bus_rdata <= {{PAD_W{1'b0}}, cnt_val};
        SEL_CALIB:  bus_rdata <= {{PAD_W{1'b0}}, calib_i};
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cur_val,
  input logic [CNT_W-1:0]  rld_val,
  input logic              en,
  input logic              ie,
  input logic              flag
);
  logic wr_cur, rd_wide;
  assign wr_cur  = bus_sel & bus_wr & (bus_addr[3:2] == 2'd2);
  assign rd_wide = bus_sel & ~bus_wr & ((bus_addr[3:2] == 2'd1) || (bus_addr[3:2] == 2'd2));

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (cur_val == '0)); // R2
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ie)); // R9
  AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_cur |=> (cur_val == '0) && !flag); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_cur) |=> $stable(cur_val)); // R1
  AST_ZERO_RELOAD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (cur_val == '0 && rld_val == '0) |=> (cur_val == '0) && !irq_o); // R8
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_wide |=> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R7
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .cur_val   (cnt_val),
  .rld_val   (reload_q),
  .en        (en_q),
  .ie        (ie_q),
  .flag      (flag_q)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 24;
  localparam logic [CNT_W-1:0] CAL = 24'h0F4240;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              ref_clk_i = 1'b0;
  logic              irq_o;

  int vectors = 0;
  int misses  = 0;
  int ref_half = 2;
  int ref_cnt  = 0;
  logic ref_run = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  tick_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .HAS_REF(1'b1)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_clk_i(ref_clk_i),
    .calib_i(CAL), .irq_o(irq_o)
  );

  // Reference generator: each phase lasts ref_half core clocks
  always @(negedge clk) begin
    if (!ref_run) begin
      ref_cnt = 0;
      ref_clk_i = 1'b0;
    end else begin
      ref_cnt = ref_cnt + 1;
      if (ref_cnt == ref_half) begin
        ref_clk_i = ~ref_clk_i;
        ref_cnt = 0;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // Cycles until irq_o is seen high, counted from the last negedge
  task automatic wait_irq(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_o) begin n = i; break; end
    end
  endtask

  task automatic idle(input int c, output int irq_seen);
    irq_seen = 0;
    for (int i = 0; i < c; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_o) irq_seen++;
    end
  endtask

  task automatic stop_timer();
    logic [31:0] d;
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0);
    rd(4'h0, d);
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", irq_o, 0);

    rd(4'h0, d); check("R1 ctrl reset", d, 0);
    rd(4'h4, d); check("R1 reload reset", d, 0);
    rd(4'h8, d); check("R1 count reset", d, 0);
    rd(4'hC, d); check("R6 calibration", d, {8'h0, CAL});

    // R7 upper bits
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R7 reload upper zero", d, 32'h00FF_FFFF);
    // disabled: count holds (R1)
    idle(5, seen);
    rd(4'h8, d); check("R1 count holds while off", d, 0);

    // R2 sweep over reload values, core clock
    for (int r = 1; r <= 6; r++) begin
      wr(4'h4, 32'(r));
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h3);
      wait_irq(100, n); check("R2 first period", n, r + 1);
      wait_irq(100, n); check("R2 steady period", n, r + 1);
      stop_timer();
    end

    // R3 sweep over reference phase lengths and reloads
    for (int k = 2; k <= 4; k++) begin
      for (int r = 1; r <= 4; r++) begin
        ref_half = k;
        ref_run = 1'b1;
        wr(4'h4, 32'(r));
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h7);
        wait_irq(500, n);
        wait_irq(500, n); check("R3 reference period", n, (r + 1) * 2 * k);
        wait_irq(500, n); check("R3 reference period repeat", n, (r + 1) * 2 * k);
        stop_timer();
        ref_run = 1'b0;
      end
    end

    // R9 + R4: interrupt disabled, flag still set, clear on read
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h1);
    idle(12, seen); check("R9 no irq with ie clear", seen, 0);
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R4 flag set after wrap", d, 32'h0001_0000);
    rd(4'h0, d); check("R4 flag cleared by read", d, 0);

    // R5: write to current value clears count and flag
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h1);
    idle(9, seen);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h1234);
    rd(4'h8, d); check("R5 count cleared", d, 0);
    rd(4'h0, d); check("R5 flag cleared", d, 0);

    // R5 mid-count restart
    wr(4'h4, 32'd20);
    wr(4'h0, 32'h3);
    idle(7, seen);
    wr(4'h8, 32'h0);
    wait_irq(100, n); check("R5 restart after write", n, 21);
    stop_timer();

    // R10 readback and R8 zero reload
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h7);
    rd(4'h0, d); check("R10 control readback", d, 32'h7);
    wr(4'h0, 32'h3);
    idle(20, seen); check("R8 no irq at zero reload", seen, 0);
    rd(4'h8, d); check("R8 count stays zero", d, 0);
    rd(4'h0, d); check("R8 flag stays clear", d, 32'h3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule